// File: doc/BRIEF.md
# Command Word Stream Decoder

The decoder sits behind a fetch unit that delivers a DMA command program as a stream of 32-bit words. It works out which words start an instruction and which carry that instruction's arguments. For a starting word it splits out the operation code, the named flag bits, the spare bits and the 12-bit count, and reports the instruction's length in words. Each following argument word is passed on with a running index from 1 upward.

The decoder does not execute anything. Instructions differ in length according to their operation code. A small counter therefore tracks how many argument words are still owed, so the decoder stays aligned on the next instruction word.

A synchronous flush input throws away any partly received instruction. The next accepted word is then treated as the start of a new instruction. All results are registered and appear as a one-cycle strobe in the clock cycle after the word is accepted.

Top module: `prog_word_decoder`

## Requirements
- R1: A word accepted while no argument words are owed is an instruction word. In the next cycle `op_valid` is high for exactly one cycle, with `op_code` = word bits 31:28 and `out_word` = the word.
- R2: With `op_valid`, `op_count` equals word bits 11:0.
- R3: With `op_valid`, `op_flags` maps word bits as follows: [0]=bit 15 (resync), [1]=bit 16, [2]=bit 17, [3]=bit 24, [4]=bit 25, [5]=bit 26 (end of line), [6]=bit 27 (start of line). `op_spare` = {bits 23:18, bits 14:12}.
- R4: `op_len` is 2 for code 0x1 (write) and 0x7 (jump), and 3 for 0xB and 0xC (masked writes). It is 4 for 0xD (control register write) and 1 for 0x2, 0x5, 0x8, 0x9 and 0xA.
- R5: Codes 0x0, 0x3, 0x4, 0x6, 0xE and 0xF raise `op_invalid` with `op_len` = 1, and the next word is again an instruction word.
- R6: The `op_len`-1 words that follow an instruction word are argument words, whatever their content. Each one gives `arg_valid` for one cycle in the next cycle, with `arg_index` counting 1, 2, 3 and `out_word` = the word.
- R7: A cycle without acceptance (`in_valid` low) produces no strobe in the next cycle and does not advance the argument tracking.
- R8: While `flush` is high, `in_ready` is low and the offered word is ignored. The flush drops any owed argument words, so the next accepted word decodes as an instruction word.
- R9: During reset and after it, both strobes are low. The first accepted word after reset is an instruction word.
- R10: `op_valid` and `arg_valid` are never high together, and each accepted word yields exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of the partial instruction |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Program word |
| op_valid | output | 1 | Strobe: instruction word decoded |
| op_code | output | 4 | Operation code |
| op_flags | output | 7 | Named flag bits |
| op_spare | output | 9 | Unnamed bits 23:18 and 14:12 |
| op_count | output | 12 | Count field |
| op_len | output | 3 | Instruction length in words |
| op_invalid | output | 1 | Operation code has no defined meaning |
| arg_valid | output | 1 | Strobe: argument word |
| arg_index | output | 2 | Position of the argument word (1..3) |
| out_word | output | 32 | The raw word behind either strobe |

## Verification
The hardest case to reach is a flush that arrives partway through a four-word instruction while a word is also being offered. The stimulus reaches it by sending a control register write instruction and part of its arguments, then raising flush together with `in_valid` and a word that would look like an argument. The scoreboard expects no strobe for the offered word and expects the following word to decode as an instruction. Argument words whose top nibble is a valid operation code are also sent, so that any loss of alignment shows up as a mismatch.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 4;
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int CNT_W   = 12;
  localparam int FLAG_N  = 7;
  localparam int SPARE_N = 9;
  localparam int LEN_W   = 3;
  localparam int IDX_W   = 2;

  localparam int unsigned FLAG_POS  [FLAG_N]  = '{15, 16, 17, 24, 25, 26, 27};
  localparam int unsigned SPARE_POS [SPARE_N] = '{12, 13, 14, 18, 19, 20, 21, 22, 23};

  localparam logic [OPC_W-1:0] C_WRITE   = 4'h1;
  localparam logic [OPC_W-1:0] C_SKIP    = 4'h2;
  localparam logic [OPC_W-1:0] C_WRITEC  = 4'h5;
  localparam logic [OPC_W-1:0] C_JUMP    = 4'h7;
  localparam logic [OPC_W-1:0] C_SYNC    = 4'h8;
  localparam logic [OPC_W-1:0] C_READ    = 4'h9;
  localparam logic [OPC_W-1:0] C_READC   = 4'hA;
  localparam logic [OPC_W-1:0] C_WRRAMM  = 4'hB;
  localparam logic [OPC_W-1:0] C_WRCTLM  = 4'hC;
  localparam logic [OPC_W-1:0] C_WRCREG  = 4'hD;
endpackage

// File: rtl/pwd_rst_sync.sv
module pwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pwd_len_table.sv
module pwd_len_table
  import pwd_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output logic [LEN_W-1:0] len_o,
  output logic             known_o
);
  always_comb begin
    known_o = 1'b1;
    len_o   = LEN_W'(1);
    case (opc_i)
      C_WRITE, C_JUMP:   len_o = LEN_W'(2);
      C_WRRAMM, C_WRCTLM: len_o = LEN_W'(3);
      C_WRCREG:          len_o = LEN_W'(4);
      C_SKIP, C_WRITEC, C_SYNC, C_READ, C_READC: len_o = LEN_W'(1);
      default:           known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwd_field_split.sv
module pwd_field_split
  import pwd_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  output logic [OPC_W-1:0]   opc_o,
  output logic [FLAG_N-1:0]  flags_o,
  output logic [SPARE_N-1:0] spare_o,
  output logic [CNT_W-1:0]   count_o
);
  assign opc_o   = word_i[WORD_W-1:OPC_LSB];
  assign count_o = word_i[CNT_W-1:0];

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    assign flags_o[f] = word_i[FLAG_POS[f]];
  end

  for (genvar s = 0; s < SPARE_N; s++) begin : g_spare
    assign spare_o[s] = word_i[SPARE_POS[s]];
  end
endmodule

// File: rtl/pwd_arg_track.sv
module pwd_arg_track
  import pwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             flush_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             is_arg_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;

  assign is_arg_o = (rem_q != '0);
  assign idx_o    = idx_q + IDX_W'(1);
  assign en       = accept_i | flush_i;

  always_comb begin
    rem_d = rem_q;
    idx_d = idx_q;
    if (flush_i) begin
      rem_d = '0;
      idx_d = '0;
    end else if (accept_i) begin
      if (is_arg_o) begin
        rem_d = rem_q - LEN_W'(1);
        idx_d = idx_o;
      end else begin
        rem_d = len_i - LEN_W'(1);
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
    end
  end

  assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= LEN_W'(3));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (rem_q == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !flush_i) |=> $stable(rem_q));
endmodule

// File: rtl/prog_word_decoder.sv
module prog_word_decoder
  import pwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               op_valid,
  output logic [OPC_W-1:0]   op_code,
  output logic [FLAG_N-1:0]  op_flags,
  output logic [SPARE_N-1:0] op_spare,
  output logic [CNT_W-1:0]   op_count,
  output logic [LEN_W-1:0]   op_len,
  output logic               op_invalid,
  output logic               arg_valid,
  output logic [IDX_W-1:0]   arg_index,
  output logic [WORD_W-1:0]  out_word
);
  logic               rst_i_n;
  logic               accept;
  logic [OPC_W-1:0]   f_opc;
  logic [FLAG_N-1:0]  f_flags;
  logic [SPARE_N-1:0] f_spare;
  logic [CNT_W-1:0]   f_count;
  logic [LEN_W-1:0]   t_len;
  logic               t_known;
  logic               trk_is_arg;
  logic [IDX_W-1:0]   trk_idx;

  logic op_v_d, op_v_q, arg_v_d, arg_v_q;
  logic [OPC_W-1:0]   code_q;
  logic [FLAG_N-1:0]  flags_q;
  logic [SPARE_N-1:0] spare_q;
  logic [CNT_W-1:0]   count_q;
  logic [LEN_W-1:0]   len_q;
  logic               inv_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  word_q;

  pwd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign in_ready = rst_i_n & ~flush;
  assign accept   = in_valid & in_ready;

  pwd_field_split u_split (
    .word_i(in_word), .opc_o(f_opc), .flags_o(f_flags),
    .spare_o(f_spare), .count_o(f_count)
  );

  pwd_len_table u_len (.opc_i(f_opc), .len_o(t_len), .known_o(t_known));

  pwd_arg_track u_trk (
    .clk(clk), .rst_n(rst_i_n), .accept_i(accept), .flush_i(flush),
    .len_i(t_len), .is_arg_o(trk_is_arg), .idx_o(trk_idx)
  );

  always_comb begin
    op_v_d  = accept & ~trk_is_arg;
    arg_v_d = accept &  trk_is_arg;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_v_q  <= 1'b0;
      arg_v_q <= 1'b0;
    end else begin
      op_v_q  <= op_v_d;
      arg_v_q <= arg_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      code_q  <= '0;
      flags_q <= '0;
      spare_q <= '0;
      count_q <= '0;
      len_q   <= '0;
      inv_q   <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
    end else if (accept) begin
      code_q  <= f_opc;
      flags_q <= f_flags;
      spare_q <= f_spare;
      count_q <= f_count;
      len_q   <= t_len;
      inv_q   <= ~t_known;
      idx_q   <= trk_idx;
      word_q  <= in_word;
    end
  end

  assign op_valid   = op_v_q;
  assign arg_valid  = arg_v_q;
  assign op_code    = code_q;
  assign op_flags   = flags_q;
  assign op_spare   = spare_q;
  assign op_count   = count_q;
  assign op_len     = len_q;
  assign op_invalid = inv_q;
  assign arg_index  = idx_q;
  assign out_word   = word_q;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(op_valid && arg_valid));

  assert_no_accept_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !accept |=> (!op_valid && !arg_valid));

  assert_arg_index_range_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    arg_valid |-> (arg_index != '0));

  assert_invalid_single_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op_valid && op_invalid) |-> (op_len == LEN_W'(1)));

  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    flush |-> !in_ready);
endmodule

// File: tb/prog_word_decoder_test.sv
module prog_word_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int ITEM_W = 71;

  logic clk, rst_n, flush, in_valid, in_ready;
  logic [31:0] in_word, out_word;
  logic op_valid, op_invalid, arg_valid;
  logic [3:0] op_code;
  logic [6:0] op_flags;
  logic [8:0] op_spare;
  logic [11:0] op_count;
  logic [2:0] op_len;
  logic [1:0] arg_index;

  int checks = 0;
  int errors = 0;
  int owed = 0;
  int next_idx = 0;
  logic [ITEM_W-1:0] expq[$];

  prog_word_decoder uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .op_valid(op_valid),
    .op_code(op_code), .op_flags(op_flags), .op_spare(op_spare),
    .op_count(op_count), .op_len(op_len), .op_invalid(op_invalid),
    .arg_valid(arg_valid), .arg_index(arg_index), .out_word(out_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [ITEM_W-1:0] act,
                       input logic [ITEM_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_len(input logic [3:0] c);
    case (c)
      4'h1, 4'h7: ref_len = 3'd2;
      4'hB, 4'hC: ref_len = 3'd3;
      4'hD:       ref_len = 3'd4;
      default:    ref_len = 3'd1;
    endcase
  endfunction

  function automatic bit ref_bad(input logic [3:0] c);
    ref_bad = (c == 4'h0) || (c == 4'h3) || (c == 4'h4) || (c == 4'h6) ||
              (c == 4'hE) || (c == 4'hF);
  endfunction

  // Drive one word, predicting its decode (R1-R6).
  task automatic send(input logic [31:0] w, input int gap);
    logic [ITEM_W-1:0] e;
    if (owed == 0) begin
      e = {1'b1, w[31:28],
           w[27], w[26], w[25], w[24], w[17], w[16], w[15],
           w[23:18], w[14:12], w[11:0], ref_len(w[31:28]),
           ref_bad(w[31:28]), 2'b00, w};
      owed = int'(ref_len(w[31:28])) - 1;
      next_idx = 1;
    end else begin
      e = {1'b0, 36'd0, 2'(next_idx), w};
      owed--;
      next_idx++;
    end
    expq.push_back(e);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Flush with a word offered at the same time (R8).
  task automatic do_flush();
    flush = 1'b1;
    in_valid = 1'b1;
    in_word = 32'hD0000ABC;
    #1;
    check(in_ready == 1'b0, "R8 in_ready low in flush", ITEM_W'(in_ready), '0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 1'b0;
    owed = 0;
    next_idx = 0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (op_valid || arg_valid)) begin
      logic [ITEM_W-1:0] a, e;
      if (op_valid)
        a = {1'b1, op_code, op_flags, op_spare, op_count, op_len, op_invalid, 2'b00, out_word};
      else
        a = {1'b0, 36'd0, arg_index, out_word};
      if (expq.size() == 0) begin
        check(1'b0, "R10/R7/R8 unexpected strobe", a, '0);
      end else begin
        e = expq.pop_front();
        check(a == e && !(op_valid && arg_valid),
              e[ITEM_W-1] ? "R1-R5 instruction decode" : "R6 argument word", a, e);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    check(!op_valid && !arg_valid && !in_ready, "R9 strobes low in reset",
          ITEM_W'({op_valid, arg_valid, in_ready}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!op_valid && !arg_valid && in_ready, "R9 idle after reset",
          ITEM_W'({op_valid, arg_valid, in_ready}), ITEM_W'(1));

    // R1 R2 R3: sync with resync and all flags, count max
    send(32'h8F0F8FFF, 0);
    send(32'h8000_8000, 0);
    // R4 write + argument resembling an opcode (R6)
    send(32'h1C00_02D0, 0);
    send(32'hD000_1234, 0);
    // jump
    send(32'h7000_0000, 1);
    send(32'h0010_0000, 0);
    // masked writes, length 3, with stalls (R7)
    send(32'hB100_0004, 2);
    send(32'h7000_0001, 0);
    send(32'h1000_0002, 3);
    send(32'hC200_0008, 0);
    send(32'hBEEF_0000, 0);
    send(32'h0000_FFFF, 0);
    // control register write, length 4
    send(32'hD200_0000, 0);
    send(32'h0031_0000, 0);
    send(32'h0000_00AA, 0);
    send(32'hFFFF_FFFF, 1);
    // single-word codes
    send(32'h2000_0010, 0);
    send(32'h5400_0020, 0);
    send(32'h9000_0030, 0);
    send(32'hA800_0040, 0);
    // R5 invalid codes then a valid one
    send(32'h0000_0001, 0);
    send(32'h3FFF_F000, 0);
    send(32'h4000_0000, 0);
    send(32'h6000_0000, 0);
    send(32'hE000_0000, 0);
    send(32'hF0FC_7000, 0);
    send(32'h7000_0005, 0);
    send(32'h0000_0100, 0);
    // R8 flush mid control-register write
    send(32'hD000_0000, 0);
    send(32'h1111_1111, 0);
    do_flush();
    repeat (2) @(negedge clk);
    send(32'h1000_0100, 0);
    send(32'h8000_0000, 0);
    // flush when idle, then back-to-back
    do_flush();
    send(32'h8000_0001, 0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R10 every word strobed once", ITEM_W'(expq.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule